// File: doc/BRIEF.md
# Lockable Seconds Watchdog with Byte Register Interface

This block is a watchdog that a host programs through four byte-wide registers: a control register, a timeout reload register, a kick register and a read-only remaining-seconds register. Once enabled, it counts down whole seconds from the programmed timeout. The second tick comes from an internal prescaler that divides the system clock by a parameter. The host keeps the watchdog alive by writing one specific magic byte to the kick register. Any other kick value leaves the countdown untouched.

When the count runs out, the block raises a system reset request, a separate timeout flag, or both. The control register selects which. Each raised output stays high until a hardware reset. A lock bit, once written as one, can only be cleared by reset. While it is set, the host cannot switch the watchdog off. The host bus bridge and any stretching of the reset pulse sit outside this block.

Top module: `guard_timer`

## Requirements
- R1: After reset the control register reads 0x00, the count register reads the `INIT_TIMEOUT` parameter value, and both expiry outputs are low.
- R2: The control register is at address 0 with enable at bit 0, lock at bit 2, reset-request permit at bit 6 and timeout-flag permit at bit 7. All other bits read as zero.
- R3: While disabled, the count register (address 3) reads the last value written to the timeout register (address 1), and no expiry output rises however long the block waits.
- R4: While enabled, the count drops by one every `CLKS_PER_SEC` clocks, starting from the timeout value. The first drop comes `CLKS_PER_SEC` clocks after the enabling write.
- R5: Writing 0x6B to the kick register (address 2) while enabled reloads the count from the timeout register and restarts the prescaler.
- R6: Writing any value other than 0x6B to the kick register leaves the count and prescaler unchanged.
- R7: A timeout value of 0 loads a count of 1, so enabling never expires at once.
- R8: One clock after the enabled count reaches 0, `sysResetOut` rises if bit 6 was set and `timeoutOut` rises if bit 7 was set. They stay high until reset, even across later kicks or disabling.
- R9: Once lock is set, a control write cannot clear lock, and a control write cannot clear enable while enable is set.
- R10: A control write that keeps enable at one does not reload or disturb the running countdown.
- R11: Without lock, writing enable as zero stops the countdown, and the count reads the timeout value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| sysResetOut | output | 1 | Sticky system reset request |
| timeoutOut | output | 1 | Sticky timeout flag |

## Verification
The bench aims at the exact clock of each second boundary and of expiry. A prescaler that is off by one, or that is not restarted by a kick, moves the count change by a cycle and is caught. It writes a wrong kick byte partway through a second. A design that reloads on any kick write would then show a full count where a decremented one is expected. It tries to disable a locked watchdog and rewrites the control bits while the countdown runs. A missing lock guard stops the count, and a spurious reload restores the full timeout. A zero timeout must not expire on the enabling cycle, and the outputs must stay high after a kick and a disable.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_RELD  = 2'd1;
  localparam logic [1:0] ADDR_KICK  = 2'd2;
  localparam logic [1:0] ADDR_COUNT = 2'd3;

  localparam int BIT_EN       = 0;
  localparam int BIT_LOCK     = 2;
  localparam int BIT_RSTPERM  = 6;
  localparam int BIT_FLAGPERM = 7;

  localparam logic [7:0] KICK_MAGIC = 8'h6B;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic       run;
    logic       reload;
    logic [7:0] loadSecs;
  } dpCmd_t;

endpackage

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
#(
  parameter int CLKS_PER_SEC = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  output logic [7:0] secsLeft,
  output logic       expireHit
);

  localparam int PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_SEC - 1);

  logic [PRE_W-1:0] preCnt;
  logic [7:0]       countQ;
  logic             expiredQ;
  logic             secTick;
  logic [7:0]       floorSecs;

  assign secTick   = (preCnt == PRE_LAST);
  assign floorSecs = (cmd.loadSecs == 8'd0) ? 8'd1 : cmd.loadSecs;
  assign expireHit = cmd.run && (countQ == 8'd0) && !expiredQ;
  assign secsLeft  = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      countQ   <= 8'd1;
      expiredQ <= 1'b0;
    end else begin
      if (expireHit) expiredQ <= 1'b1;
      if (!cmd.run) begin
        preCnt <= '0;
        countQ <= floorSecs;
      end else if (cmd.reload && !expiredQ) begin
        preCnt <= '0;
        countQ <= floorSecs;
      end else if (secTick) begin
        preCnt <= '0;
        if (countQ != 8'd0) countQ <= countQ - 8'd1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R4: count only moves on a second boundary or a reload
  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.reload && !secTick) |=> (countQ == $past(countQ)));

  // R4: a zero count never wraps around
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.reload && countQ == 8'd0) |=> (countQ == 8'd0));

  // R7: a reload never leaves a zero count
  assert_reload_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && cmd.reload && !expiredQ) |=> (countQ != 8'd0));

  // R8: expiry state is sticky
  assert_expired_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    expiredQ |=> expiredQ);

endmodule

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
#(
  parameter logic [7:0] INIT_TIMEOUT = 8'd10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [7:0] secsLeft,
  input  logic       expireHit,
  output dpCmd_t     cmd,
  output logic       sysResetOut,
  output logic       timeoutOut
);

  logic       enQ;
  logic       lockQ;
  logic       rstPermQ;
  logic       flagPermQ;
  logic [7:0] reloadQ;
  logic       sysRstQ;
  logic       flagQ;
  logic       ctrlWr;
  logic       reldWr;
  logic       kickOk;
  logic [7:0] ctrlView;

  assign ctrlWr = busWrEn && (busAddr == ADDR_CTRL);
  assign reldWr = busWrEn && (busAddr == ADDR_RELD);
  assign kickOk = busWrEn && (busAddr == ADDR_KICK) && (busWrData == KICK_MAGIC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      lockQ     <= 1'b0;
      rstPermQ  <= 1'b0;
      flagPermQ <= 1'b0;
      reloadQ   <= INIT_TIMEOUT;
    end else begin
      if (ctrlWr) begin
        enQ       <= busWrData[BIT_EN] | (lockQ & enQ);
        lockQ     <= busWrData[BIT_LOCK] | lockQ;
        rstPermQ  <= busWrData[BIT_RSTPERM];
        flagPermQ <= busWrData[BIT_FLAGPERM];
      end
      if (reldWr) reloadQ <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysRstQ <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (expireHit && rstPermQ)  sysRstQ <= 1'b1;
      if (expireHit && flagPermQ) flagQ   <= 1'b1;
    end
  end

  always_comb begin
    cmd.run      = enQ;
    cmd.reload   = kickOk && enQ;
    cmd.loadSecs = reloadQ;
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[BIT_EN]       = enQ;
    ctrlView[BIT_LOCK]     = lockQ;
    ctrlView[BIT_RSTPERM]  = rstPermQ;
    ctrlView[BIT_FLAGPERM] = flagPermQ;
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL:  busRdData = ctrlView;
      ADDR_RELD:  busRdData = reloadQ;
      ADDR_COUNT: busRdData = enQ ? secsLeft : reloadQ;
      default:    busRdData = 8'h00;
    endcase
  end

  assign sysResetOut = sysRstQ;
  assign timeoutOut  = flagQ;

  // R9: lock never clears
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // R9: a locked running watchdog stays running
  assert_lock_holds_en_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && enQ) |=> enQ);

  // R3: no output rises while disabled
  assert_quiet_disabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !sysRstQ && !flagQ) |=> (!sysRstQ && !flagQ));

  // R8: outputs are sticky
  assert_outputs_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sysRstQ || flagQ) |=> ((sysRstQ || !$past(sysRstQ)) && (flagQ || !$past(flagQ))));

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int         CLKS_PER_SEC = 50_000_000,
  parameter logic [7:0] INIT_TIMEOUT = 8'd10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       sysResetOut,
  output logic       timeoutOut
);

  dpCmd_t     cmd;
  logic [7:0] secsLeft;
  logic       expireHit;

  guard_timer_ctrl #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .secsLeft    (secsLeft),
    .expireHit   (expireHit),
    .cmd         (cmd),
    .sysResetOut (sysResetOut),
    .timeoutOut  (timeoutOut)
  );

  guard_timer_dp #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .secsLeft  (secsLeft),
    .expireHit (expireHit)
  );

endmodule

// File: tb/guard_timer_bench.sv
`timescale 1ns/1ps
module guard_timer_bench;

  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       sysResetOut;
  logic       timeoutOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  guard_timer #(.CLKS_PER_SEC(P), .INIT_TIMEOUT(8'd10)) u_guard_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .sysResetOut(sysResetOut), .timeoutOut(timeoutOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [1:0] a, input int exp);
    busAddr = a;
    #1;
    chk(tag, int'(busRdData), exp);
  endtask

  task automatic outChk(input string tag, input bit r, input bit t);
    chk({tag, " sysResetOut"}, int'(sysResetOut), int'(r));
    chk({tag, " timeoutOut"}, int'(timeoutOut), int'(t));
  endtask

  task automatic t_reset();
    doReset();
    rdChk("R1 ctrl after reset", 2'd0, 8'h00);
    rdChk("R1 count after reset", 2'd3, 10);
    outChk("R1", 0, 0);
  endtask

  task automatic t_ctrlBits();
    wr(2'd0, 8'hFE);
    rdChk("R2 ctrl field layout", 2'd0, 8'hC4);
    wr(2'd0, 8'h00);
    rdChk("R9 lock not clearable", 2'd0, 8'h04);
    doReset();
  endtask

  task automatic t_disabled();
    wr(2'd1, 8'd5);
    repeat (10 * P) @(negedge clk);
    rdChk("R3 count mirrors timeout", 2'd3, 5);
    outChk("R3", 0, 0);
  endtask

  task automatic t_countKickExpire();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'hC1);
    rdChk("R4 start value", 2'd3, 3);
    repeat (P - 1) @(negedge clk);
    rdChk("R4 before first second", 2'd3, 3);
    @(negedge clk);
    rdChk("R4 first second", 2'd3, 2);
    wr(2'd2, 8'h00);
    rdChk("R6 bad kick ignored", 2'd3, 2);
    repeat (P - 2) @(negedge clk);
    rdChk("R6 prescaler not restarted", 2'd3, 1);
    wr(2'd2, 8'h6B);
    rdChk("R5 magic kick reload", 2'd3, 3);
    repeat (P - 1) @(negedge clk);
    rdChk("R5 prescaler restarted", 2'd3, 3);
    @(negedge clk);
    rdChk("R5 first second after kick", 2'd3, 2);
    repeat (2 * P) @(negedge clk);
    rdChk("R8 count at zero", 2'd3, 0);
    outChk("R8 not yet", 0, 0);
    @(negedge clk);
    outChk("R8 expiry both", 1, 1);
    wr(2'd2, 8'h6B);
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    outChk("R8 sticky", 1, 1);
    doReset();
  endtask

  task automatic t_resetOnly();
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h41);
    repeat (P) @(negedge clk);
    outChk("R8 rst-only at zero", 0, 0);
    @(negedge clk);
    outChk("R8 rst-only expiry", 1, 0);
    doReset();
  endtask

  task automatic t_zeroTimeout();
    wr(2'd1, 8'd0);
    rdChk("R3 zero timeout readback", 2'd3, 0);
    wr(2'd0, 8'h81);
    rdChk("R7 zero loads one", 2'd3, 1);
    outChk("R7 no instant expiry", 0, 0);
    repeat (P) @(negedge clk);
    rdChk("R7 reaches zero", 2'd3, 0);
    @(negedge clk);
    outChk("R7 flag-only expiry", 0, 1);
    doReset();
  endtask

  task automatic t_lock();
    wr(2'd1, 8'd6);
    wr(2'd0, 8'h05);
    repeat (P) @(negedge clk);
    wr(2'd0, 8'h00);
    rdChk("R9 enable held by lock", 2'd0, 8'h05);
    rdChk("R9 still counting", 2'd3, 5);
    doReset();
  endtask

  task automatic t_runtimeCtrl();
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h01);
    repeat (P) @(negedge clk);
    rdChk("R10 first second", 2'd3, 3);
    wr(2'd0, 8'hC1);
    rdChk("R10 ctrl updated", 2'd0, 8'hC1);
    rdChk("R10 no reload", 2'd3, 3);
    repeat (P - 1) @(negedge clk);
    rdChk("R10 cadence kept", 2'd3, 2);
    wr(2'd0, 8'h00);
    rdChk("R11 disable shows timeout", 2'd3, 4);
    repeat (6 * P) @(negedge clk);
    rdChk("R11 stopped", 2'd3, 4);
    outChk("R11 no expiry", 0, 0);
    doReset();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ctrlBits();
    t_disabled();
    t_countKickExpire();
    t_resetOnly();
    t_zeroTimeout();
    t_lock();
    t_runtimeCtrl();
    finishRun();
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule